// File: doc/BRIEF.md
# Vectored Interrupt Entry and Return-Address Stack Controller

This block sits beside the fetch unit of a small 8-bit CPU. It decides which interrupt request is taken at an instruction boundary and produces the vector address the program counter must jump to. It also keeps the return addresses of interrupts and subroutine calls in an ordinary byte-wide data memory, in a stack that grows toward lower addresses. The CPU asks it to push on a call and to pop on a return or a return-from-interrupt. The block owns the global interrupt enable, which it clears on entry and sets again on return-from-interrupt. Software can still write that bit at any time.

Requests are prioritised by position. Source `k` jumps to `VEC_BASE + 2*(k+1)`, because slot 0 of the vector table is kept for reset. The stack pointer is a 16-bit register that software loads before the first call. Each 16-bit return address takes two byte accesses through the memory port. The status register is not saved or restored here; software handles that.

Top module: `vec_irq_ctrl`

## Requirements
- R1: Among sources with both `irqPend[k]` and `irqEn[k]` high, the lowest index `k` wins. The vector driven is `VEC_BASE + 2*(k+1)`, and `irqAckId` equals `k`. With no such source, no interrupt is taken and the stack is untouched.
- R2: While `gieOut` is 0, no interrupt is accepted, whatever `irqPend` and `irqEn` hold.
- R3: Accepting an interrupt clears `gieOut` at the accepting edge. Finishing a return-from-interrupt sets it to 1. Otherwise `gieWrEn` loads `gieWrData`. The enable resets to 0.
- R4: An interrupt is accepted only in a cycle with `instrBoundary` high while the controller is idle. `pcLoad` and `irqAck` are high in the fourth cycle, counted from the accepting cycle as cycle 1.
- R5: A push writes the byte at address SP and then decrements SP. A 16-bit return address is pushed low byte first. It is sampled from `retPc` in the accepting cycle, so the low byte lands at SP and the high byte at SP-1.
- R6: A pop first increments SP and then reads at the new SP, high byte first. `memRdata` is taken to be valid one cycle after `memRe`. On `retReq` or `retiReq`, `pcLoad` is high in the fourth cycle after the request cycle, with `pcLoadValue` set to the popped address. At that point SP is back at its value before the matching push.
- R7: `callReq` pushes `retPc` in two cycles and never raises `pcLoad`.
- R8: A `callReq`, `retReq` or `retiReq` seen while idle takes precedence over an interrupt in the same cycle. Any such request made while `busy` is high is ignored.
- R9: After a return-from-interrupt, the first `instrBoundary` pulse never accepts an interrupt. The next pulse may accept one.
- R10: SP resets to 0. While idle, `spWrEn` loads it from `spWrData`. It wraps modulo 2^16, so a push at SP 0 writes address 0 and then address 0xFFFF.
- R11: A plain return (`retReq`) leaves `gieOut` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| irqPend | input | NUM_SRC | Pending request per source |
| irqEn | input | NUM_SRC | Individual enable per source |
| instrBoundary | input | 1 | An instruction has just completed |
| retPc | input | 16 | Return address to push on call or interrupt entry |
| callReq | input | 1 | Subroutine call: push `retPc` |
| retReq | input | 1 | Subroutine return: pop and reload PC |
| retiReq | input | 1 | Return from interrupt: pop, reload PC, set enable |
| gieWrEn | input | 1 | Software write strobe for the global enable |
| gieWrData | input | 1 | Value written to the global enable |
| gieOut | output | 1 | Current global interrupt enable |
| spWrEn | input | 1 | Software write strobe for the stack pointer |
| spWrData | input | 16 | Value written to the stack pointer |
| spOut | output | 16 | Current stack pointer |
| busy | output | 1 | A stack sequence is in progress |
| pcLoad | output | 1 | Program counter must load `pcLoadValue` |
| pcLoadValue | output | 16 | Vector address or popped return address |
| irqAck | output | 1 | Interrupt vector being issued this cycle |
| irqAckId | output | $clog2(NUM_SRC) | Index of the source being serviced |
| memWe | output | 1 | Stack byte write |
| memRe | output | 1 | Stack byte read |
| memAddr | output | 16 | Stack byte address |
| memWdata | output | 8 | Byte to write |
| memRdata | input | 8 | Byte read, valid the cycle after `memRe` |

## Verification
The bench builds the block with `NUM_SRC = 4` and `VEC_BASE = 0x0040`, which makes every pattern of pending and enable bits reachable. It sweeps all 256 of those patterns. Each taken interrupt is checked against the lowest set bit and then unwound through a return-from-interrupt, and every pending pattern is repeated with the enable cleared. A 256-byte memory model decodes only the low address byte, so the wrap of a push at SP 0 lands in visible bytes 0x00 and 0xFF.

// File: rtl/vec_irq_pkg.sv
package vec_irq_pkg;

  localparam int PtrW  = 16;
  localparam int ByteW = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PSH_LO,
    ST_PSH_HI,
    ST_VEC,
    ST_POP_HI,
    ST_POP_LO,
    ST_POP_CAP,
    ST_RET_JMP
  } ctrl_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic spWrite;
    logic latchIrq;
    logic latchCall;
    logic pushLo;
    logic pushHi;
    logic popHi;
    logic popLo;
    logic capLo;
    logic loadVec;
    logic loadRet;
  } stack_stb_t;

endpackage

// File: rtl/vec_irq_ctrl_dp.sv
module vec_irq_ctrl_dp
  import vec_irq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter logic [15:0] VEC_BASE = 16'h0000,
  localparam int SrcW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  stack_stb_t           stb,
  input  logic [NUM_SRC-1:0]   irqPend,
  input  logic [NUM_SRC-1:0]   irqEn,
  input  logic [PtrW-1:0]      retPc,
  input  logic [PtrW-1:0]      spWrData,
  input  logic [ByteW-1:0]     memRdata,
  output logic                 winValid,
  output logic [SrcW-1:0]      ackId,
  output logic [PtrW-1:0]      spOut,
  output logic [PtrW-1:0]      memAddr,
  output logic [ByteW-1:0]     memWdata,
  output logic [PtrW-1:0]      pcLoadValue
);

  logic [NUM_SRC-1:0] live;
  logic [SrcW-1:0]    winId;
  logic [PtrW-1:0]    sp;
  logic [PtrW-1:0]    spNext;
  logic [PtrW-1:0]    retReg;
  logic [ByteW-1:0]   hiReg;
  logic [ByteW-1:0]   loReg;
  logic [PtrW-1:0]    vecAddr;

  assign live = irqPend & irqEn;

  // fixed priority: scan from top so the lowest live index is left last
  always_comb begin
    winValid = 1'b0;
    winId    = '0;
    for (int k = NUM_SRC - 1; k >= 0; k--) begin
      if (live[k]) begin
        winValid = 1'b1;
        winId    = SrcW'(k);
      end
    end
  end

  assign spNext = (stb.pushLo || stb.pushHi) ? sp - 16'd1 :
                  (stb.popHi  || stb.popLo)  ? sp + 16'd1 :
                  stb.spWrite                ? spWrData   : sp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sp     <= '0;
      retReg <= '0;
      ackId  <= '0;
      hiReg  <= '0;
      loReg  <= '0;
    end else begin
      sp <= spNext;
      if (stb.latchIrq || stb.latchCall) retReg <= retPc;
      if (stb.latchIrq) ackId <= winId;
      if (stb.popLo) hiReg <= memRdata;
      if (stb.capLo) loReg <= memRdata;
    end
  end

  // pops address the incremented pointer, pushes the current one
  assign memAddr  = (stb.popHi || stb.popLo) ? sp + 16'd1 : sp;
  assign memWdata = stb.pushHi ? retReg[15:8] : retReg[7:0];

  assign vecAddr     = VEC_BASE + (PtrW'(ackId) << 1) + 16'd2;
  assign pcLoadValue = stb.loadVec ? vecAddr : {hiReg, loReg};
  assign spOut       = sp;

endmodule

// File: rtl/vec_irq_ctrl_fsm.sv
module vec_irq_ctrl_fsm
  import vec_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       instrBoundary,
  input  logic       winValid,
  input  logic       callReq,
  input  logic       retReq,
  input  logic       retiReq,
  input  logic       gieWrEn,
  input  logic       gieWrData,
  input  logic       spWrEn,
  output stack_stb_t stb,
  output logic       gieOut,
  output logic       busy
);

  ctrl_state_e state;
  ctrl_state_e nxt;
  logic        gie;
  logic        holdOff;
  logic        isIrq;
  logic        isReti;
  logic        anyRet;

  assign anyRet = retReq || retiReq;

  always_comb begin
    nxt = state;
    stb = '0;
    unique case (state)
      ST_IDLE: begin
        stb.spWrite = spWrEn;
        if (callReq) begin
          stb.latchCall = 1'b1;
          nxt = ST_PSH_LO;
        end else if (anyRet) begin
          nxt = ST_POP_HI;
        end else if (instrBoundary && gie && winValid && !holdOff) begin
          stb.latchIrq = 1'b1;
          nxt = ST_PSH_LO;
        end
      end
      ST_PSH_LO: begin
        stb.pushLo = 1'b1;
        nxt = ST_PSH_HI;
      end
      ST_PSH_HI: begin
        stb.pushHi = 1'b1;
        nxt = isIrq ? ST_VEC : ST_IDLE;
      end
      ST_VEC: begin
        stb.loadVec = 1'b1;
        nxt = ST_IDLE;
      end
      ST_POP_HI: begin
        stb.popHi = 1'b1;
        nxt = ST_POP_LO;
      end
      ST_POP_LO: begin
        stb.popLo = 1'b1;
        nxt = ST_POP_CAP;
      end
      ST_POP_CAP: begin
        stb.capLo = 1'b1;
        nxt = ST_RET_JMP;
      end
      ST_RET_JMP: begin
        stb.loadRet = 1'b1;
        nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      gie     <= 1'b0;
      holdOff <= 1'b0;
      isIrq   <= 1'b0;
      isReti  <= 1'b0;
    end else begin
      state <= nxt;
      if (stb.latchIrq) isIrq <= 1'b1;
      else if (stb.latchCall) isIrq <= 1'b0;
      if (state == ST_IDLE && anyRet && !callReq) isReti <= retiReq;
      // hardware actions override the software write
      if (stb.latchIrq) gie <= 1'b0;
      else if (stb.capLo && isReti) gie <= 1'b1;
      else if (gieWrEn) gie <= gieWrData;
      if (stb.capLo && isReti) holdOff <= 1'b1;
      else if (state == ST_IDLE && instrBoundary) holdOff <= 1'b0;
    end
  end

  assign gieOut = gie;
  assign busy   = (state != ST_IDLE);

endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vec_irq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter logic [15:0] VEC_BASE = 16'h0000,
  localparam int SrcW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqPend,
  input  logic [NUM_SRC-1:0] irqEn,
  input  logic               instrBoundary,
  input  logic [15:0]        retPc,
  input  logic               callReq,
  input  logic               retReq,
  input  logic               retiReq,
  input  logic               gieWrEn,
  input  logic               gieWrData,
  output logic               gieOut,
  input  logic               spWrEn,
  input  logic [15:0]        spWrData,
  output logic [15:0]        spOut,
  output logic               busy,
  output logic               pcLoad,
  output logic [15:0]        pcLoadValue,
  output logic               irqAck,
  output logic [SrcW-1:0]    irqAckId,
  output logic               memWe,
  output logic               memRe,
  output logic [15:0]        memAddr,
  output logic [7:0]         memWdata,
  input  logic [7:0]         memRdata
);

  stack_stb_t stb;
  logic       winValid;

  vec_irq_ctrl_fsm ctrl_i (
    .clk(clk), .rstN(rstN), .instrBoundary(instrBoundary), .winValid(winValid),
    .callReq(callReq), .retReq(retReq), .retiReq(retiReq),
    .gieWrEn(gieWrEn), .gieWrData(gieWrData), .spWrEn(spWrEn),
    .stb(stb), .gieOut(gieOut), .busy(busy)
  );

  vec_irq_ctrl_dp #(.NUM_SRC(NUM_SRC), .VEC_BASE(VEC_BASE)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .irqPend(irqPend), .irqEn(irqEn),
    .retPc(retPc), .spWrData(spWrData), .memRdata(memRdata),
    .winValid(winValid), .ackId(irqAckId), .spOut(spOut),
    .memAddr(memAddr), .memWdata(memWdata), .pcLoadValue(pcLoadValue)
  );

  assign pcLoad = stb.loadVec || stb.loadRet;
  assign irqAck = stb.loadVec;
  assign memWe  = stb.pushLo || stb.pushHi;
  assign memRe  = stb.popHi || stb.popLo;

endmodule

// File: rtl/vec_irq_ctrl_chk.sv
module vec_irq_ctrl_chk #(
  parameter int NUM_SRC = 8,
  parameter logic [15:0] VEC_BASE = 16'h0000,
  localparam int SrcW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input logic            clk,
  input logic            rstN,
  input logic            busy,
  input logic            instrBoundary,
  input logic            gieOut,
  input logic            callReq,
  input logic            retReq,
  input logic            retiReq,
  input logic            latchIrq,
  input logic            irqAck,
  input logic [SrcW-1:0] irqAckId,
  input logic [15:0]     pcLoadValue,
  input logic            memWe,
  input logic            memRe,
  input logic [15:0]     spOut
);

  // R2: a cleared enable blocks acceptance
  a_r2_no_take_when_off: assert property (@(posedge clk) disable iff (!rstN)
    (!gieOut) |-> !latchIrq);

  // R3: acceptance clears the enable
  a_r3_entry_clears_gie: assert property (@(posedge clk) disable iff (!rstN)
    latchIrq |=> !gieOut);

  // R1: issued vector matches the serviced index
  a_r1_vector_addr: assert property (@(posedge clk) disable iff (!rstN)
    irqAck |-> pcLoadValue == 16'(VEC_BASE + 16'(irqAckId) * 16'd2 + 16'd2));

  // R4: vector issue directly follows the high-byte push
  a_r4_vec_after_push: assert property (@(posedge clk) disable iff (!rstN)
    irqAck |-> $past(memWe));

  // R5: every push moves the pointer down by one
  a_r5_push_decrements: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> spOut == $past(spOut) - 16'd1);

  // R6: every pop moves the pointer up by one
  a_r6_pop_increments: assert property (@(posedge clk) disable iff (!rstN)
    memRe |=> spOut == $past(spOut) + 16'd1);

  // R5: reads and writes never share a cycle
  a_r5_rw_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && memRe));

  // R8: an idle stack request beats an interrupt in the same cycle
  a_r8_request_first: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && (callReq || retReq || retiReq)) |-> !latchIrq);

  // R4: nothing is accepted outside an instruction boundary
  a_r4_boundary_only: assert property (@(posedge clk) disable iff (!rstN)
    (!instrBoundary) |-> !latchIrq);

endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk #(.NUM_SRC(NUM_SRC), .VEC_BASE(VEC_BASE)) chk_i (
  .clk(clk), .rstN(rstN), .busy(busy), .instrBoundary(instrBoundary),
  .gieOut(gieOut), .callReq(callReq), .retReq(retReq), .retiReq(retiReq),
  .latchIrq(stb.latchIrq), .irqAck(irqAck), .irqAckId(irqAckId),
  .pcLoadValue(pcLoadValue), .memWe(memWe), .memRe(memRe), .spOut(spOut)
);

// File: tb/vec_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module vec_irq_ctrl_tb_top;

  localparam int NS = 4;
  localparam logic [15:0] VB = 16'h0040;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NS-1:0] irqPend = '0;
  logic [NS-1:0] irqEn = '0;
  logic instrBoundary = 1'b0;
  logic [15:0] retPc = '0;
  logic callReq = 1'b0, retReq = 1'b0, retiReq = 1'b0;
  logic gieWrEn = 1'b0, gieWrData = 1'b0;
  logic gieOut;
  logic spWrEn = 1'b0;
  logic [15:0] spWrData = '0;
  logic [15:0] spOut;
  logic busy, pcLoad, irqAck;
  logic [15:0] pcLoadValue;
  logic [1:0] irqAckId;
  logic memWe, memRe;
  logic [15:0] memAddr;
  logic [7:0] memWdata;
  logic [7:0] memRdata = '0;
  logic [7:0] mem [0:255];

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  vec_irq_ctrl #(.NUM_SRC(NS), .VEC_BASE(VB)) dut_i (
    .clk(clk), .rstN(rstN), .irqPend(irqPend), .irqEn(irqEn),
    .instrBoundary(instrBoundary), .retPc(retPc), .callReq(callReq),
    .retReq(retReq), .retiReq(retiReq), .gieWrEn(gieWrEn), .gieWrData(gieWrData),
    .gieOut(gieOut), .spWrEn(spWrEn), .spWrData(spWrData), .spOut(spOut),
    .busy(busy), .pcLoad(pcLoad), .pcLoadValue(pcLoadValue), .irqAck(irqAck),
    .irqAckId(irqAckId), .memWe(memWe), .memRe(memRe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata)
  );

  // byte memory with one-cycle read latency
  always @(posedge clk) begin
    if (memWe) mem[memAddr[7:0]] <= memWdata;
    if (memRe) memRdata <= mem[memAddr[7:0]];
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic setSp(input logic [15:0] v);
    spWrEn = 1'b1; spWrData = v;
    @(negedge clk);
    spWrEn = 1'b0;
  endtask

  task automatic setGie(input logic b);
    gieWrEn = 1'b1; gieWrData = b;
    @(negedge clk);
    gieWrEn = 1'b0;
  endtask

  task automatic pulseBoundary();
    instrBoundary = 1'b1;
    @(negedge clk);
    instrBoundary = 1'b0;
  endtask

  // strobes are driven by the caller; this releases them after one cycle
  task automatic waitLoad(input int maxCy, output int lat, output bit seen,
                          output logic [15:0] val, output logic [1:0] id);
    seen = 1'b0; lat = 0; val = '0; id = '0;
    for (int i = 1; i <= maxCy; i++) begin
      @(negedge clk);
      if (i == 1) begin
        instrBoundary = 1'b0; callReq = 1'b0; retReq = 1'b0; retiReq = 1'b0;
      end
      if (!seen && pcLoad) begin
        seen = 1'b1; lat = i; val = pcLoadValue; id = irqAckId;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    bit seen;
    logic [15:0] val;
    logic [1:0] id;
    logic [15:0] pc;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10: reset state
    chk(spOut == 16'h0000, "R10 reset sp", spOut, 0);
    chk(gieOut == 1'b0, "R3 reset gie", gieOut, 0);
    chk(!busy && !pcLoad, "R4 reset idle", {busy, pcLoad}, 0);

    // R10/R7: push at SP 0 wraps, call never loads PC
    retPc = 16'hBEEF; callReq = 1'b1;
    waitLoad(3, lat, seen, val, id);
    chk(!seen, "R7 call no pcLoad", seen, 0);
    chk(spOut == 16'hFFFE, "R10 wrap sp", spOut, 16'hFFFE);
    chk(mem[8'h00] == 8'hEF, "R5 low byte at sp", mem[8'h00], 8'hEF);
    chk(mem[8'hFF] == 8'hBE, "R10 high byte at wrapped addr", mem[8'hFF], 8'hBE);
    retReq = 1'b1;
    waitLoad(5, lat, seen, val, id);
    chk(seen && lat == 4, "R6 ret latency", lat, 4);
    chk(val == 16'hBEEF, "R6 popped pc", val, 16'hBEEF);
    chk(spOut == 16'h0000, "R10 sp restored", spOut, 0);
    chk(gieOut == 1'b0, "R11 ret keeps gie 0", gieOut, 0);

    // R11: plain return leaves gie at 1
    setGie(1'b1);
    retPc = 16'h1234; callReq = 1'b1;
    waitLoad(3, lat, seen, val, id);
    retReq = 1'b1;
    waitLoad(5, lat, seen, val, id);
    chk(val == 16'h1234, "R6 popped pc", val, 16'h1234);
    chk(gieOut == 1'b1, "R11 ret keeps gie 1", gieOut, 1);

    // R1/R3/R4/R5/R6: sweep every pending and enable pattern
    for (int p = 0; p < 16; p++) begin
      for (int e = 0; e < 16; e++) begin
        int k;
        k = -1;
        for (int b = NS - 1; b >= 0; b--) if (p[b] && e[b]) k = b;
        setSp(16'h0080);
        setGie(1'b1);
        pc = 16'hA000 | 16'(p * 16 + e);
        irqPend = 4'(p); irqEn = 4'(e); retPc = pc; instrBoundary = 1'b1;
        waitLoad(4, lat, seen, val, id);
        if (k >= 0) begin
          chk(seen && lat == 3, "R4 entry latency", lat, 3);
          chk(val == 16'(VB + 2 * (k + 1)), "R1 vector", val, 16'(VB + 2 * (k + 1)));
          chk(id == 2'(k), "R1 ack id", id, k);
          chk(gieOut == 1'b0, "R3 entry clears gie", gieOut, 0);
          chk(spOut == 16'h007E, "R5 sp after push", spOut, 16'h007E);
          chk(mem[8'h80] == pc[7:0], "R5 low byte", mem[8'h80], pc[7:0]);
          chk(mem[8'h7F] == pc[15:8], "R5 high byte", mem[8'h7F], pc[15:8]);
          irqPend = '0; retiReq = 1'b1;
          waitLoad(5, lat, seen, val, id);
          chk(seen && lat == 4, "R6 reti latency", lat, 4);
          chk(val == pc, "R6 reti pc", val, pc);
          chk(gieOut == 1'b1, "R3 reti sets gie", gieOut, 1);
          chk(spOut == 16'h0080, "R6 sp after pop", spOut, 16'h0080);
          pulseBoundary();
        end else begin
          chk(!seen, "R1 no winner", seen, 0);
          chk(spOut == 16'h0080, "R1 stack untouched", spOut, 16'h0080);
        end
      end
    end
    irqPend = '0;

    // R2: global enable off blocks every pattern
    for (int p = 1; p < 16; p++) begin
      setSp(16'h0080);
      setGie(1'b0);
      irqPend = 4'(p); irqEn = 4'hF; instrBoundary = 1'b1;
      waitLoad(4, lat, seen, val, id);
      chk(!seen && !busy, "R2 gie off no entry", seen, 0);
      chk(spOut == 16'h0080, "R2 sp unchanged", spOut, 16'h0080);
    end
    irqPend = '0;

    // R9: one boundary of hold-off after reti
    setSp(16'h0080);
    setGie(1'b1);
    irqPend = 4'b0010; irqEn = 4'hF; retPc = 16'h1111; instrBoundary = 1'b1;
    waitLoad(4, lat, seen, val, id);
    chk(seen && val == 16'h0044, "R1 vector src1", val, 16'h0044);
    retiReq = 1'b1;
    waitLoad(5, lat, seen, val, id);
    instrBoundary = 1'b1;
    waitLoad(4, lat, seen, val, id);
    chk(!seen && !busy, "R9 first boundary blocked", seen, 0);
    instrBoundary = 1'b1;
    waitLoad(4, lat, seen, val, id);
    chk(seen && lat == 3, "R9 second boundary taken", lat, 3);
    irqPend = '0; retiReq = 1'b1;
    waitLoad(5, lat, seen, val, id);
    pulseBoundary();

    // R8: call wins over an interrupt in the same cycle
    setSp(16'h0080);
    setGie(1'b1);
    irqPend = 4'b0001; irqEn = 4'hF; retPc = 16'h2222;
    callReq = 1'b1; instrBoundary = 1'b1;
    waitLoad(4, lat, seen, val, id);
    chk(!seen, "R8 call beats irq", seen, 0);
    chk(spOut == 16'h007E, "R8 only call pushed", spOut, 16'h007E);
    chk(gieOut == 1'b1, "R8 gie untouched", gieOut, 1);

    // R8: request during entry is ignored
    instrBoundary = 1'b1;
    @(negedge clk);
    instrBoundary = 1'b0; retReq = 1'b1;
    @(negedge clk);
    retReq = 1'b0;
    @(negedge clk);
    chk(pcLoad && pcLoadValue == 16'h0042, "R8 entry completes", pcLoadValue, 16'h0042);
    @(negedge clk);
    chk(spOut == 16'h007C && !busy, "R8 busy request ignored", spOut, 16'h007C);
    irqPend = '0; retiReq = 1'b1;
    waitLoad(5, lat, seen, val, id);
    chk(val == 16'h2222 && spOut == 16'h007E, "R6 nested pop", val, 16'h2222);
    retReq = 1'b1;
    waitLoad(5, lat, seen, val, id);
    chk(val == 16'h2222 && spOut == 16'h0080, "R6 outer pop", spOut, 16'h0080);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule